// File: doc/BRIEF.md
# Write-Once Nonvolatile Clock Divider Register

This block holds the clock-rate setting for a nonvolatile memory controller and produces the divided clock enable from it. Software writes a prescale-enable bit and a six-bit divide value once after reset. That write also sets a read-only loaded flag. Every later write is dropped, so the setting cannot be changed until the next reset.

The divided clock appears as a one-cycle enable pulse. Its rate is the input clock divided by (8 if prescale is set, else 1) times (divide value + 1). While the register is unloaded, the divider is held idle and no pulse appears. The same loaded flag gives permission for program and erase operations. A start request made before loading raises a one-cycle error pulse.

Top module: `nvm_clkdiv`

## Requirements
- R1: After reset the read data is 8'h00, the permit output is 0 and no clock enable pulse appears.
- R2: The first write after reset stores write data bits 6:0 into register bits 6:0 and sets read bit 7 to 1 in the following cycle, whatever value write data bit 7 has.
- R3: Every write after the first leaves the read data unchanged until reset.
- R4: Read data bit 6 is the prescale enable, and bits 5:0 are the divide value D.
- R5: With prescale clear, clk_en_o pulses for exactly one cycle every D+1 cycles. The first pulse comes D+1 cycles after the cycle in which the loaded flag rises.
- R6: With prescale set, clk_en_o pulses for one cycle every 8*(D+1) cycles, counted from the cycle in which the loaded flag rises.
- R7: While the loaded flag is 0, clk_en_o stays 0.
- R8: pe_permit_o equals read bit 7, the loaded flag.
- R9: A start request while pe_permit_o is 0 gives a one-cycle acc_err_o pulse in the next cycle. A request while pe_permit_o is 1 gives no pulse.
- R10: A write strobe without the address select has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register address match |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data {loaded, prescale, divide} |
| clk_en_o | output | 1 | Divided clock enable pulse |
| pe_start_i | input | 1 | Program/erase start request |
| pe_permit_o | output | 1 | Program/erase permitted |
| acc_err_o | output | 1 | One-cycle access error pulse |

## Verification
The divider is run with several settings: D=0 without prescale, which gives a pulse every cycle, and D=2 without prescale, which gives the short period. D=2 with prescale shows that the factor of eight is applied on top of D+1, and D=63 with prescale reaches the largest period. Each setting needs its own reset because of the write-once rule. Repeated writes with different data, including a write with bit 7 set, separate a correct one-shot latch from one that can be reloaded. Start requests made before and after loading separate a correct permit gate from one that errors always or never.

// File: rtl/nvm_clkdiv_pkg.sv
package nvm_clkdiv_pkg;
  localparam int DIV_W = 6;
  localparam int PRE_FACTOR = 8;
  localparam int PRE_W = $clog2(PRE_FACTOR);
  typedef struct packed {
    logic             loaded;
    logic             pre_en;
    logic [DIV_W-1:0] div;
  } cfg_t;
endpackage

// File: rtl/nvm_clkdiv_reg.sv
module nvm_clkdiv_reg
  import nvm_clkdiv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output cfg_t       cfg_o
);
  logic wr_ok;
  assign wr_ok = sel_i && we_i && !cfg_o.loaded;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_o <= '0;
    else if (wr_ok) begin
      cfg_o.loaded <= 1'b1;
      cfg_o.pre_en <= wdata_i[6];
      cfg_o.div    <= wdata_i[DIV_W-1:0];
    end
  end
endmodule

// File: rtl/nvm_clkdiv_core.sv
module nvm_clkdiv_core
  import nvm_clkdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             pre_en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_en_o
);
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_tick;

  assign pre_tick = !pre_en_i || (pre_cnt == PRE_W'(PRE_FACTOR-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt  <= '0;
      div_cnt  <= '0;
      clk_en_o <= 1'b0;
    end else if (!run_i) begin
      pre_cnt  <= '0;
      div_cnt  <= '0;
      clk_en_o <= 1'b0;
    end else begin
      clk_en_o <= 1'b0;
      if (pre_en_i) pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
      if (pre_tick) begin
        if (div_cnt == div_i) begin
          div_cnt  <= '0;
          clk_en_o <= 1'b1;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nvm_clkdiv_gate.sv
module nvm_clkdiv_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic loaded_i,
  input  logic start_i,
  output logic permit_o,
  output logic err_o
);
  assign permit_o = loaded_i;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= start_i && !loaded_i;
  end
endmodule

// File: rtl/nvm_clkdiv.sv
module nvm_clkdiv
  import nvm_clkdiv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       clk_en_o,
  input  logic       pe_start_i,
  output logic       pe_permit_o,
  output logic       acc_err_o
);
  cfg_t cfg;

  nvm_clkdiv_reg u_reg (
    .clk_i, .rst_ni, .sel_i, .we_i, .wdata_i, .cfg_o(cfg)
  );

  nvm_clkdiv_core u_core (
    .clk_i, .rst_ni,
    .run_i(cfg.loaded), .pre_en_i(cfg.pre_en), .div_i(cfg.div),
    .clk_en_o
  );

  nvm_clkdiv_gate u_gate (
    .clk_i, .rst_ni, .loaded_i(cfg.loaded), .start_i(pe_start_i),
    .permit_o(pe_permit_o), .err_o(acc_err_o)
  );

  assign rdata_o = cfg;
endmodule

// File: rtl/nvm_clkdiv_chk.sv
module nvm_clkdiv_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       we_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       clk_en_o,
  input logic       pe_start_i,
  input logic       pe_permit_o,
  input logic       acc_err_o
);
  // R2
  always @(posedge clk_i)
    if (rst_ni) first_wr_chk: assert (!(($past(rst_ni) && $past(sel_i && we_i && !rdata_o[7])) && (rdata_o[6:0] != $past(wdata_i[6:0]))));

  // R3
  locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[7] |=> $stable(rdata_o));

  // R7
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[7] |-> !clk_en_o);

  // R8
  permit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_permit_o == rdata_o[7]);

  // R9
  err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_start_i && !pe_permit_o) |=> acc_err_o);

  // R9
  no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pe_start_i || pe_permit_o) |=> !acc_err_o);

  // R10
  nosel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && !rdata_o[7]) |=> !rdata_o[7]);
endmodule

bind nvm_clkdiv nvm_clkdiv_chk u_chk (.*);

// File: tb/nvm_clkdiv_test.sv
`timescale 1ns/1ps
module nvm_clkdiv_test;
  logic clk_i = 0, rst_ni = 0, sel_i = 0, we_i = 0, pe_start_i = 0;
  logic [7:0] wdata_i = 0;
  logic [7:0] rdata_o;
  logic clk_en_o, pe_permit_o, acc_err_o;
  int errs = 0, checks = 0;

  always #2 clk_i = ~clk_i;

  nvm_clkdiv uut (.*);

  // behavioural reference
  logic [7:0] m_reg;
  int m_cnt, m_per;
  bit m_en, m_err;
  bit mon = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_reg = 0; m_cnt = 0; m_en = 0; m_err = 0; m_per = 1;
    end else begin
      m_err = pe_start_i && !m_reg[7];
      if (m_reg[7]) begin
        m_cnt++;
        m_en = (m_cnt % m_per) == 0;
      end else m_en = 0;
      if (sel_i && we_i && !m_reg[7]) begin
        m_reg = {1'b1, wdata_i[6:0]};
        m_per = (wdata_i[6] ? 8 : 1) * (wdata_i[5:0] + 1);
        m_cnt = 0;
      end
    end
  end

  always @(negedge clk_i) if (mon && rst_ni) begin
    chk("R2/R3/R4", rdata_o, m_reg);
    chk("R5/R6/R7", clk_en_o, m_en);
    chk("R8", pe_permit_o, m_reg[7]);
    chk("R9", acc_err_o, m_err);
  end

  task automatic do_reset();
    mon = 0;
    rst_ni = 0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i);
    chk("R1 rdata", rdata_o, 8'h00);
    chk("R1 permit", pe_permit_o, 0);
    chk("R1 clk_en", clk_en_o, 0);
    mon = 1;
  endtask

  task automatic wr(logic s, logic [7:0] d);
    @(negedge clk_i);
    sel_i = s; we_i = 1; wdata_i = d;
    @(negedge clk_i);
    sel_i = 0; we_i = 0;
  endtask

  task automatic start_req();
    @(negedge clk_i);
    pe_start_i = 1;
    @(negedge clk_i);
    pe_start_i = 0;
  endtask

  task automatic run_cfg(logic [7:0] d, int cycles);
    do_reset();
    start_req();          // R9 error path
    wr(0, 8'h55);         // R10 unselected write
    repeat (4) @(negedge clk_i);
    chk("R10", rdata_o, 8'h00);
    chk("R7", clk_en_o, 0);
    wr(1, d);             // R2 first write
    chk("R2", rdata_o, {1'b1, d[6:0]});
    wr(1, ~d);            // R3 ignored
    wr(1, 8'h00);
    chk("R3", rdata_o, {1'b1, d[6:0]});
    start_req();          // R9 no error
    repeat (cycles) @(negedge clk_i);
  endtask

  initial begin
    fork
      begin
        run_cfg(8'h00, 20);   // R5 divide by 1
        run_cfg(8'h02, 30);   // R5 divide by 3
        run_cfg(8'hC2, 80);   // R6 prescale, bit7 set in write
        run_cfg(8'h7F, 1100); // R6 max
      end
      begin
        repeat (20000) @(posedge clk_i);
        errs++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule